// File: doc/BRIEF.md
# Parity-Filtered Binary Associative Lookup

This block is an exact-match associative table. Software-side logic writes words into numbered slots, and a lookup then presents a key and gets back every slot that holds that key. Each slot keeps a one-bit tag beside its word. The tag is the XOR of the word's bits, and the block recomputes it on every write.

A lookup runs in two steps. The first step compares the key's own XOR tag with every slot's tag. A slot passes only if it is occupied and its tag agrees. The second step compares the full word, and it does so only for the slots that passed. The result is a per-slot hit vector, a flag that is set when anything hit, and the index of the lowest hitting slot. The block also reports how many slots reached the full comparison, which serves as a measure of comparator activity.

The table is scanned as a whole in every lookup. A new lookup can start on every clock.

Top module: `pcam_search`

## Requirements
- R1: After reset every slot is unoccupied and `res_valid`, `res_hit`, `res_addr`, `res_match` and `res_active` are all zero. A lookup issued right after reset therefore misses, with an activity count of 0.
- R2: A write with `wr_en` high stores `wr_data` in slot `wr_addr`, together with the XOR of its bits. The slot becomes occupied when `wr_valid` is 1 and unoccupied when `wr_valid` is 0.
- R3: A lookup is accepted on a rising edge where `srch_start` is high. Its results appear after the next rising edge, and `res_valid` is high for exactly that one cycle unless another lookup follows.
- R4: Bit i of `res_match` is 1 only when slot i is occupied, its stored tag equals the key's XOR, and all data bits equal the key. A tag agreement with unequal data, or equal data in an unoccupied slot, gives 0.
- R5: When several slots hit, `res_match` shows all of them and `res_addr` gives the lowest hitting index.
- R6: `res_hit` is 1 exactly when `res_match` is nonzero. On a miss, `res_addr` is 0.
- R7: `res_active` equals the number of occupied slots whose stored tag equals the key's XOR.
- R8: A write in the same cycle as the lookup's `srch_start` is not seen by that lookup. It is seen by every lookup that starts later.
- R9: Lookups may start on consecutive cycles. Each one produces its own result, in order, one cycle apart.
- R10: Between results, the result outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Slot to write |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Occupancy value given to the slot |
| srch_start | input | 1 | Starts a lookup |
| srch_key | input | WIDTH | Key to look up |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | At least one slot hit |
| res_addr | output | AW | Lowest hitting slot |
| res_match | output | ENTRIES | Per-slot hit vector |
| res_active | output | CW | Count of slots that reached the full comparison |

## Verification
The bench targets the following corner cases:

- **Tag agreement with different data.** A slot whose tag agrees but whose data differs must not hit. A design that trusted the tag alone would report false hits.
- **Unoccupied slot with equal data.** A slot that holds the key but is unoccupied must stay silent. A design that ignored occupancy would report a hit on it.
- **Duplicate keys.** These expose an encoder that favours the highest index.
- **Same-cycle write.** A lookup issued in the same cycle as a write to a slot it compares against must see the old contents. A design without a snapshot would return the new word one lookup early.
- **Back-to-back lookups.** These catch stage registers that drop or mix results.
- **Activity count.** The count is compared with a model that counts tag agreements among occupied slots. A design that counted hits instead, or counted unoccupied slots, would differ from it.

// File: rtl/pcam_search.sv
module pcam_search #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               wr_valid,
  input  logic               srch_start,
  input  logic [WIDTH-1:0]   srch_key,
  output logic               res_valid,
  output logic               res_hit,
  output logic [AW-1:0]      res_addr,
  output logic [ENTRIES-1:0] res_match,
  output logic [CW-1:0]      res_active
);

  logic [WIDTH-1:0]   mem_data [ENTRIES];
  logic [ENTRIES-1:0] mem_par, mem_vld;

  wire wr_ok   = wr_en && (int'(wr_addr) < ENTRIES);
  wire key_par = ^srch_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_par <= '0;
      mem_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) mem_data[i] <= '0;
    end else if (wr_ok) begin
      mem_data[wr_addr] <= wr_data;
      mem_par[wr_addr]  <= ^wr_data;
      mem_vld[wr_addr]  <= wr_valid;
    end
  end

  logic [ENTRIES-1:0] filt_d;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      filt_d[i] = mem_vld[i] && (mem_par[i] == key_par);
  end

  logic               s1_v;
  logic [WIDTH-1:0]   s1_key;
  logic [ENTRIES-1:0] s1_filt;
  logic               snap_en;
  logic [AW-1:0]      snap_addr;
  logic [WIDTH-1:0]   snap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_key    <= '0;
      s1_filt   <= '0;
      snap_en   <= 1'b0;
      snap_addr <= '0;
      snap_data <= '0;
    end else begin
      s1_v <= srch_start;
      if (srch_start) begin
        s1_key    <= srch_key;
        s1_filt   <= filt_d;
        snap_en   <= wr_ok;
        snap_addr <= wr_addr;
        snap_data <= wr_ok ? mem_data[wr_addr] : '0;
      end
    end
  end

  logic [ENTRIES-1:0] match_d;
  logic [AW-1:0]      addr_d;
  logic [CW-1:0]      cnt_d;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (snap_en && snap_addr == AW'(i))
        match_d[i] = s1_filt[i] && (snap_data == s1_key);
      else
        match_d[i] = s1_filt[i] && (mem_data[i] == s1_key);
    end
  end

  always_comb begin
    addr_d = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_d[i]) addr_d = AW'(i);
  end

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < ENTRIES; i++) cnt_d = cnt_d + CW'(s1_filt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_addr   <= '0;
      res_match  <= '0;
      res_active <= '0;
    end else begin
      res_valid <= s1_v;
      if (s1_v) begin
        res_hit    <= |match_d;
        res_addr   <= addr_d;
        res_match  <= match_d;
        res_active <= cnt_d;
      end
    end
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(srch_start, 2));

  // R5
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> ((res_match & ((ENTRIES'(1) << res_addr) - ENTRIES'(1))) == '0));

  // R6
  hit_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_match[res_addr]);

  // R7
  active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_match) <= int'(res_active)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_match) && $stable(res_addr) && $stable(res_active)));

endmodule

// File: tb/pcam_search_bench.sv
module pcam_search_bench;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int AW = 3;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_valid = 1'b0, srch_start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0, srch_key = '0;
  logic res_valid, res_hit;
  logic [AW-1:0] res_addr;
  logic [N-1:0]  res_match;
  logic [CW-1:0] res_active;

  pcam_search #(.ENTRIES(N), .WIDTH(W)) u_pcam_search (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .srch_start(srch_start),
    .srch_key(srch_key), .res_valid(res_valid), .res_hit(res_hit),
    .res_addr(res_addr), .res_match(res_match), .res_active(res_active));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] ref_data [N];
  logic [N-1:0] ref_vld = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] key, output logic [N-1:0] m,
                       output logic [AW-1:0] a, output logic [CW-1:0] c);
    m = '0; a = '0; c = '0;
    for (int i = 0; i < N; i++) begin
      if (ref_vld[i] && (^ref_data[i] == ^key)) begin
        c = c + 1'b1;
        if (ref_data[i] == key) m[i] = 1'b1;
      end
    end
    for (int i = N - 1; i >= 0; i--) if (m[i]) a = AW'(i);
  endtask

  task automatic check_res(input string req, input logic [N-1:0] m,
                           input logic [AW-1:0] a, input logic [CW-1:0] c);
    chk(res_valid === 1'b1, req, "res_valid", res_valid, 1);
    chk(res_match === m, req, "res_match", res_match, m);
    chk(res_hit === (m != 0), req, "res_hit", res_hit, m != 0);
    chk(res_addr === a, req, "res_addr", res_addr, a);
    chk(res_active === c, req, "res_active", res_active, c);
  endtask

  task automatic do_write(input int adr, input logic [W-1:0] d, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(adr); wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    ref_data[adr] = d; ref_vld[adr] = v;
  endtask

  task automatic do_search(input logic [W-1:0] key, input string req);
    logic [N-1:0] m; logic [AW-1:0] a; logic [CW-1:0] c;
    model(key, m, a, c);
    @(negedge clk);
    srch_start = 1'b1; srch_key = key;
    @(negedge clk);
    srch_start = 1'b0;
    @(negedge clk);
    check_res(req, m, a, c);
  endtask

  task automatic test_reset;
    chk(res_valid === 1'b0 && res_hit === 1'b0 && res_addr === '0, "R1",
        "strobe/hit/addr", {res_valid, res_hit, res_addr}, 0);
    chk(res_match === '0 && res_active === '0, "R1", "match/active",
        {res_match, res_active}, 0);
    do_search(16'h0000, "R1");
  endtask

  task automatic test_fill;
    do_write(0, 16'h0003, 1'b1);
    do_write(1, 16'h00A5, 1'b1);
    do_write(2, 16'h1234, 1'b1);
    do_write(3, 16'h0001, 1'b1);
    do_write(4, 16'h00A5, 1'b0);
    do_write(5, 16'h1234, 1'b1);
    do_write(6, 16'h0005, 1'b1);
    do_write(7, 16'hFFFF, 1'b1);
    do_search(16'h0003, "R4_R7");
    do_search(16'h0006, "R4_R6");
    do_search(16'h00A5, "R4");
    do_search(16'hFFFF, "R7");
  endtask

  task automatic test_dupes;
    do_search(16'h1234, "R5");
    do_write(2, 16'h1234, 1'b0);
    do_search(16'h1234, "R2");
  endtask

  task automatic test_same_cycle;
    logic [N-1:0] m; logic [AW-1:0] a; logic [CW-1:0] c;
    model(16'h1234, m, a, c);
    @(negedge clk);
    srch_start = 1'b1; srch_key = 16'h1234;
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1234; wr_valid = 1'b1;
    @(negedge clk);
    srch_start = 1'b0; wr_en = 1'b0;
    ref_data[3] = 16'h1234; ref_vld[3] = 1'b1;
    @(negedge clk);
    check_res("R8", m, a, c);
    do_search(16'h1234, "R8");
  endtask

  task automatic test_back_to_back;
    logic [N-1:0] m0, m1, m2; logic [AW-1:0] a0, a1, a2; logic [CW-1:0] c0, c1, c2;
    model(16'h0003, m0, a0, c0);
    model(16'h00A5, m1, a1, c1);
    model(16'h1234, m2, a2, c2);
    @(negedge clk);
    srch_start = 1'b1; srch_key = 16'h0003;
    @(negedge clk);
    srch_key = 16'h00A5;
    @(negedge clk);
    check_res("R9", m0, a0, c0);
    srch_key = 16'h1234;
    @(negedge clk);
    check_res("R9", m1, a1, c1);
    srch_start = 1'b0;
    @(negedge clk);
    check_res("R9", m2, a2, c2);
    @(negedge clk);
    chk(res_valid === 1'b0, "R3", "strobe after last", res_valid, 0);
  endtask

  task automatic test_hold;
    logic [N-1:0] m; logic [AW-1:0] a; logic [CW-1:0] c;
    model(16'h0005, m, a, c);
    do_search(16'h0005, "R10");
    @(negedge clk);
    chk(res_valid === 1'b0, "R3", "one-cycle strobe", res_valid, 0);
    srch_key = 16'hFFFF;
    do_write(6, 16'h7777, 1'b1);
    repeat (2) @(negedge clk);
    chk(res_match === m && res_addr === a && res_active === c, "R10",
        "held result", {res_match, res_addr, res_active}, {m, a, c});
  endtask

  initial begin
    for (int i = 0; i < N; i++) ref_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset;
    test_fill;
    test_dupes;
    test_same_cycle;
    test_back_to_back;
    test_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule